// File: doc/BRIEF.md
# Two-Phase Compressed Word Read Reconstructor

This block sits on the read path of a cache whose 64-bit words are stored in one of two compressed forms. It runs a read in two phases. In the header phase it asks the array for a mode flag, the six most significant stored bits and one zero flag per byte. From that header it derives a bitline enable mask. In the data phase it asks the array to sense only the enabled bitlines, and from the partial word that comes back it rebuilds the original 64-bit value.

The mode flag selects between two rebuilds. In run-length mode the top six stored bits hold a count `c`. Only the low `64 - c` bits are stored. The missing upper bits are a copy of the highest stored bit, bit `63 - c`. In byte mode, every byte whose zero flag is set reads as zero, and the other bytes are taken from the array. In both modes the top six bits already came back with the header, so they are never sensed a second time.

The request side is a valid/ready pair. `rd_ready` is high only while the block is idle. A request is taken on a cycle where both `rd_valid` and `rd_ready` are high. Holding `rd_valid` high during a read only stalls the requester and has no other effect. The array side is a pair of request/acknowledge handshakes. Each strobe stays high until its acknowledge arrives, so the array may answer after any number of cycles. The result comes out as a one-cycle `out_valid` pulse and has no back-pressure.

Top module: `cmpr_rd_top`

## Requirements
- R1: After reset, and whenever the block is idle, `rd_ready` is 1. A request accepted on clock edge k makes `hdr_req` 1 and `rd_ready` 0 from edge k onwards.
- R2: `bl_en` is all zero whenever `dat_req` is 0. This covers idle, the header phase and the output cycle.
- R3: `hdr_req` stays 1 until the edge where `hdr_ack` is 1. `dat_req` is 1 from that edge until the edge where `dat_ack` is 1. `hdr_req` and `dat_req` are never 1 together.
- R4: In run-length mode (header flag 1, count `c = hdr_top`), `bl_en` bit i is 1 exactly when i < 64 - c.
- R5: In byte mode (header flag 0), `bl_en` bit i is 1 exactly when `hdr_zib[i/8]` is 0 and i < 58.
- R6: `bl_en[63:58]` is always 0.
- R7: In run-length mode, `out_word[i]` equals `dat_in[i]` for i < 64 - c. For every other bit it equals `dat_in[63 - c]`.
- R8: In byte mode, every byte whose zero flag is set is zero in `out_word`. Bits 63:58 of a byte-7 value that is not flagged come from the captured `hdr_top`. All other bits come from `dat_in`.
- R9: `dat_in` bits whose `bl_en` bit is 0 do not affect `out_word`. Header inputs are sampled only on the `hdr_ack` edge.
- R10: `out_valid` is 1 for exactly the one cycle after the `dat_ack` edge. `out_word` keeps its value until the next result.
- R11: After reset, `hdr_req`, `dat_req` and `out_valid` are 0, and `out_word` is 0.
- R12: While a read is in progress, `rd_valid` is ignored. `rd_ready` stays 0 and the phase in progress continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_valid | input | 1 | Read request valid |
| rd_ready | output | 1 | Ready to accept a read (idle) |
| hdr_req | output | 1 | Header phase strobe to the array |
| hdr_ack | input | 1 | Header returned this cycle |
| hdr_ce | input | 1 | Mode flag: 1 run-length, 0 byte |
| hdr_top | input | 6 | Top six stored bits (count in run-length mode) |
| hdr_zib | input | 8 | Per-byte zero flags |
| dat_req | output | 1 | Data phase strobe to the array |
| bl_en | output | 64 | Bitline enable mask for the data phase |
| dat_ack | input | 1 | Partial data returned this cycle |
| dat_in | input | 64 | Sensed data (only enabled bits meaningful) |
| out_valid | output | 1 | One-cycle result pulse |
| out_word | output | 64 | Reconstructed word |

## Verification
The assertions assume that a run-length header always carries a count of at least six, because the writer never produces a smaller one. A smaller count would let the stored low bits reach the header columns. They also assume that the acknowledges arrive only while their own strobe is high. The stimulus sweeps the run-length count from 6 to 63 and drives acknowledges only inside the matching phase. It also fills every bit that is not enabled, and every header input outside the capture edge, with unrelated values.

// File: rtl/cmpr_rd_pkg.sv
package cmpr_rd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HDR  = 2'd1,
    ST_DATA = 2'd2
  } rd_state_e;
endpackage

// File: rtl/cmpr_rd_seq.sv
module cmpr_rd_seq
  import cmpr_rd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic rd_valid,
  input  logic hdr_ack,
  input  logic dat_ack,
  output logic rd_ready,
  output logic hdr_req,
  output logic dat_req,
  output logic hdr_take,
  output logic dat_take
);
  rd_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (rd_valid) state_d = ST_HDR;
      ST_HDR:  if (hdr_ack)  state_d = ST_DATA;
      ST_DATA: if (dat_ack)  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign rd_ready = (state_q == ST_IDLE);
  assign hdr_req  = (state_q == ST_HDR);
  assign dat_req  = (state_q == ST_DATA);
  assign hdr_take = hdr_req && hdr_ack;
  assign dat_take = dat_req && dat_ack;

  // R3
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hdr_req && dat_req));
  // R3
  hdr_to_dat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_take |=> dat_req);
  // R12
  hdr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_req && !hdr_ack) |=> (hdr_req && !rd_ready));
  // R1
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready) |=> (hdr_req && !rd_ready));
endmodule

// File: rtl/cmpr_rd_mask.sv
module cmpr_rd_mask #(
  parameter int WORD_W = 64,
  parameter int CNT_W  = 6,
  parameter int NBYTES = 8
) (
  input  logic              ce,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [NBYTES-1:0] zib,
  output logic [WORD_W-1:0] keep_lo,
  output logic [WORD_W-1:0] en_mask
);
  localparam int HDR_LO = WORD_W - CNT_W;

  for (genvar i = 0; i < WORD_W; i++) begin : g_bit
    assign keep_lo[i] = (int'(cnt) + i) < WORD_W;
    if (i >= HDR_LO) begin : g_hdr
      assign en_mask[i] = 1'b0;
    end else begin : g_dat
      assign en_mask[i] = ce ? keep_lo[i] : ~zib[i/8];
    end
  end
endmodule

// File: rtl/cmpr_rd_rebuild.sv
module cmpr_rd_rebuild #(
  parameter int WORD_W = 64,
  parameter int CNT_W  = 6,
  parameter int NBYTES = 8
) (
  input  logic              ce,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [NBYTES-1:0] zib,
  input  logic [WORD_W-1:0] keep_lo,
  input  logic [WORD_W-1:0] dat_in,
  output logic [WORD_W-1:0] word
);
  localparam int HDR_LO = WORD_W - CNT_W;

  logic [CNT_W-1:0]  sel;
  logic              fill;
  logic [WORD_W-1:0] run_word, byte_word;

  assign sel  = CNT_W'(WORD_W - 1) - cnt;
  assign fill = dat_in[sel];

  for (genvar i = 0; i < WORD_W; i++) begin : g_bit
    assign run_word[i] = keep_lo[i] ? dat_in[i] : fill;
    if (i >= HDR_LO) begin : g_hdr
      assign byte_word[i] = zib[i/8] ? 1'b0 : cnt[i-HDR_LO];
    end else begin : g_dat
      assign byte_word[i] = zib[i/8] ? 1'b0 : dat_in[i];
    end
  end

  assign word = ce ? run_word : byte_word;
endmodule

// File: rtl/cmpr_rd_top.sv
module cmpr_rd_top #(
  parameter int WORD_W = 64,
  parameter int CNT_W  = $clog2(WORD_W),
  parameter int NBYTES = WORD_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_valid,
  output logic              rd_ready,
  output logic              hdr_req,
  input  logic              hdr_ack,
  input  logic              hdr_ce,
  input  logic [CNT_W-1:0]  hdr_top,
  input  logic [NBYTES-1:0] hdr_zib,
  output logic              dat_req,
  output logic [WORD_W-1:0] bl_en,
  input  logic              dat_ack,
  input  logic [WORD_W-1:0] dat_in,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_word
);
  localparam int HDR_LO = WORD_W - CNT_W;

  logic              hdr_take, dat_take;
  logic              ce_q;
  logic [CNT_W-1:0]  top_q;
  logic [NBYTES-1:0] zib_q;
  logic [WORD_W-1:0] keep_lo, en_mask, word_d;

  cmpr_rd_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_valid (rd_valid),
    .hdr_ack  (hdr_ack),
    .dat_ack  (dat_ack),
    .rd_ready (rd_ready),
    .hdr_req  (hdr_req),
    .dat_req  (dat_req),
    .hdr_take (hdr_take),
    .dat_take (dat_take)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_q  <= 1'b0;
      top_q <= '0;
      zib_q <= '0;
    end else if (hdr_take) begin
      ce_q  <= hdr_ce;
      top_q <= hdr_top;
      zib_q <= hdr_zib;
    end
  end

  cmpr_rd_mask #(.WORD_W(WORD_W), .CNT_W(CNT_W), .NBYTES(NBYTES)) u_mask (
    .ce      (ce_q),
    .cnt     (top_q),
    .zib     (zib_q),
    .keep_lo (keep_lo),
    .en_mask (en_mask)
  );

  assign bl_en = dat_req ? en_mask : '0;

  cmpr_rd_rebuild #(.WORD_W(WORD_W), .CNT_W(CNT_W), .NBYTES(NBYTES)) u_rebuild (
    .ce      (ce_q),
    .cnt     (top_q),
    .zib     (zib_q),
    .keep_lo (keep_lo),
    .dat_in  (dat_in & en_mask),
    .word    (word_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_word  <= '0;
    end else begin
      out_valid <= dat_take;
      if (dat_take) out_word <= word_d;
    end
  end

  // R2
  idle_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dat_req |-> (bl_en == '0));
  // R6
  hdr_cols_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bl_en[WORD_W-1:HDR_LO] == '0);
  // R4
  thermo_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_req && ce_q) |-> (((bl_en + 1'b1) & bl_en) == '0));
  // R10
  out_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
  // R10
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dat_take |=> $stable(out_word));
  // R7 input range: run-length count never reaches the header columns
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_req && ce_q) |-> (int'(top_q) >= CNT_W));
endmodule

// File: tb/cmpr_rd_top_bench.sv
module cmpr_rd_top_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_valid = 1'b0;
  logic        rd_ready, hdr_req, dat_req, out_valid;
  logic        hdr_ack = 1'b0;
  logic        hdr_ce = 1'b0;
  logic [5:0]  hdr_top = '0;
  logic [7:0]  hdr_zib = '0;
  logic        dat_ack = 1'b0;
  logic [63:0] dat_in = '0;
  logic [63:0] bl_en, out_word;

  int n_chk = 0;
  int n_bad = 0;
  logic [63:0] rs = 64'h9E37_79B9_7F4A_7C15;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmpr_rd_top u_cmpr_rd_top (
    .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .hdr_req(hdr_req), .hdr_ack(hdr_ack), .hdr_ce(hdr_ce), .hdr_top(hdr_top),
    .hdr_zib(hdr_zib), .dat_req(dat_req), .bl_en(bl_en), .dat_ack(dat_ack),
    .dat_in(dat_in), .out_valid(out_valid), .out_word(out_word)
  );

  function automatic logic [63:0] nxt();
    rs = rs ^ (rs << 13);
    rs = rs ^ (rs >> 7);
    rs = rs ^ (rs << 17);
    return rs;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic do_read(input bit ce, input logic [5:0] top, input logic [7:0] zib,
                         input logic [63:0] stored, input logic [63:0] exp_mask,
                         input logic [63:0] exp_word, input int hdly, input int ddly);
    logic [63:0] g;
    @(negedge clk);
    chk(rd_ready == 1'b1, "R1 ready idle", 64'(rd_ready), 64'd1);
    rd_valid = 1'b1;
    @(negedge clk);
    rd_valid = 1'b0;
    chk(hdr_req && !rd_ready, "R1 hdr_req after accept", {hdr_req, rd_ready}, 64'b10);
    chk(bl_en == '0, "R2 mask off in header", bl_en, 64'd0);
    for (int k = 0; k < hdly; k++) begin
      rd_valid = 1'b1;
      hdr_ce = nxt() & 1; hdr_top = 6'(nxt()); hdr_zib = 8'(nxt());
      @(negedge clk);
      chk(hdr_req && !rd_ready && !dat_req, "R12 busy holds header",
          {hdr_req, rd_ready, dat_req}, 64'b100);
    end
    rd_valid = 1'b0;
    hdr_ce = ce; hdr_top = top; hdr_zib = zib; hdr_ack = 1'b1;
    @(negedge clk);
    hdr_ack = 1'b0;
    hdr_ce = ~ce; hdr_top = 6'(nxt()); hdr_zib = 8'(nxt());
    chk(dat_req && !hdr_req, "R3 data phase", {dat_req, hdr_req}, 64'b10);
    chk(bl_en == exp_mask, ce ? "R4 run mask" : "R5 byte mask", bl_en, exp_mask);
    chk(bl_en[63:58] == '0, "R6 header columns", bl_en, exp_mask);
    g = nxt();
    dat_in = (stored & exp_mask) | (g & ~exp_mask);
    for (int k = 0; k < ddly; k++) begin
      @(negedge clk);
      chk(dat_req && !out_valid, "R3 data hold", {dat_req, out_valid}, 64'b10);
    end
    dat_ack = 1'b1;
    @(negedge clk);
    dat_ack = 1'b0;
    dat_in = nxt();
    chk(out_valid == 1'b1, "R10 valid pulse", 64'(out_valid), 64'd1);
    chk(out_word == exp_word, ce ? "R7 R9 run rebuild" : "R8 R9 byte rebuild",
        out_word, exp_word);
    chk(!dat_req && bl_en == '0, "R2 mask off after", bl_en, 64'd0);
    @(negedge clk);
    chk(!out_valid && out_word == exp_word, "R10 pulse ends, word held",
        out_word, exp_word);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog act=%h exp=%h", 64'd0, 64'd1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [63:0] m, low, orig, bm, stv;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(rd_ready && !hdr_req && !dat_req && !out_valid && out_word == '0,
        "R11 reset", {rd_ready, hdr_req, dat_req, out_valid}, 64'b1000);
    rst_n = 1'b1;
    // run-length mode sweep: count 6..63
    for (int c = 6; c < 64; c++) begin
      m = (64'd1 << (64 - c)) - 1;
      for (int p = 0; p < 5; p++) begin
        case (p)
          0: low = '0;
          1: low = '1;
          2: low = 64'hAAAA_AAAA_AAAA_AAAA;
          default: low = nxt();
        endcase
        orig = low[63 - c] ? ((low & m) | ~m) : (low & m);
        stv  = (orig & m) | (64'(c) << 58);
        do_read(1'b1, 6'(c), 8'(nxt()), stv, m, orig, p % 3, (p + c) % 3);
      end
    end
    // byte mode sweep: every zero-flag pattern
    for (int z = 0; z < 256; z++) begin
      bm = '0;
      for (int b = 0; b < 8; b++) if (!z[b]) bm[b*8 +: 8] = 8'hFF;
      orig = nxt();
      do_read(1'b0, orig[63:58], 8'(z), orig, bm & 64'h03FF_FFFF_FFFF_FFFF,
              orig & bm, z % 2, z % 3);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule